// File: doc/BRIEF.md
# Fractional Multiply-Accumulate Datapath

This block is the arithmetic core of a small signal-processing engine. Two 16-bit operand registers hold signed fractions in Q15 form: 0x8000 stands for -1.0 and 0x7FFF for the largest value below +1.0. A write to either operand register starts a multiplication. The fractional result goes into a 32-bit product register on the same clock edge. The other operand register keeps the value it last held.

A 3-bit command works on a 40-bit accumulator, which has eight guard bits above the 32-bit fractional word. The command can load the sign-extended product, add it, subtract it, clear the accumulator, or limit the accumulator back into the 32-bit range. All accumulator commands use the product register as it stands before the current edge. The usual inner loop therefore writes both operands and issues an add in the same cycle, which folds the previous product into the sum while the next product is formed. Zero and negative flags follow every accumulator write. A multiply-overflow flag reports the single saturating operand pair, and a sticky limit flag records any clamp the limiter has made.

Top module: `fmac_top`

## Requirements
- R1: After synchronous reset, the accumulator and the product register read zero, `flag_zero` is 1, and `flag_neg`, `flag_mulovf` and `flag_lim` are 0.
- R2: In a cycle with `x_we` or `y_we` high (or both), the product register takes the signed product of the two operands shifted left by one bit. The product is visible after that edge. An operand that is not written keeps its previous value.
- R3: The operand pair 0x8000 × 0x8000 yields product 0x7FFFFFFF and sets `flag_mulovf`. Every other multiplication clears `flag_mulovf`.
- R4: With neither operand written, the product register and `flag_mulovf` keep their values.
- R5: Command 3'd1 loads the accumulator with the product register sign-extended to 40 bits.
- R6: Command 3'd2 adds the sign-extended product to the accumulator and command 3'd3 subtracts it, both modulo 2^40. Each uses the product value held before that edge.
- R7: Command 3'd4 sets the accumulator to zero.
- R8: Command 3'd5 leaves the accumulator unchanged when bits 39..31 are all equal. Otherwise it clamps the accumulator to 0x007FFFFFFF (bit 39 clear) or 0xFF80000000 (bit 39 set) and sets `flag_lim`. `flag_lim` stays set until reset.
- R9: On commands 3'd1 to 3'd5, `flag_zero` and `flag_neg` take (new accumulator == 0) and new bit 39. On other commands they hold.
- R10: Commands 3'd0, 3'd6 and 3'd7 leave the accumulator unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| x_we | input | 1 | Write strobe for operand X |
| x_in | input | 16 | Q15 value for operand X |
| y_we | input | 1 | Write strobe for operand Y |
| y_in | input | 16 | Q15 value for operand Y |
| acc_op | input | 3 | Accumulator command |
| acc_out | output | 40 | Accumulator contents |
| prod_out | output | 32 | Product register contents |
| flag_zero | output | 1 | Accumulator is zero after its last write |
| flag_neg | output | 1 | Accumulator is negative after its last write |
| flag_mulovf | output | 1 | Last multiplication saturated |
| flag_lim | output | 1 | Sticky: the limiter has clamped |

## Verification
The assertions expect `acc_op` and the write strobes to be known (never X) on every clock edge after reset. The product-hold property also expects the strobes to be the only source of multiplications. The bench drives every input from a defined value at the falling edge, so all of these hold. Its random phase uses all eight command codes, including the unused ones. Directed sequences push the accumulator past both 32-bit bounds and past the 40-bit wrap, so the limiter and the modulo arithmetic are exercised at their boundaries rather than only near zero.

// File: rtl/fmac_pkg.sv
package fmac_pkg;

    parameter int DW = 16;
    parameter int GW = 8;
    localparam int PW = 2 * DW;
    localparam int AW = PW + GW;

    typedef enum logic [2:0] {
        OP_NOP   = 3'd0,
        OP_LOAD  = 3'd1,
        OP_ADD   = 3'd2,
        OP_SUB   = 3'd3,
        OP_CLR   = 3'd4,
        OP_LIMIT = 3'd5,
        OP_RSV6  = 3'd6,
        OP_RSV7  = 3'd7
    } acc_op_e;

    typedef struct packed {
        logic [PW-1:0] value;
        logic          ovf;
    } prod_t;

    typedef struct packed {
        logic [AW-1:0] value;
        logic          clamped;
    } limit_t;

    localparam logic [DW-1:0] Q_MIN   = {1'b1, {(DW-1){1'b0}}};
    localparam logic [PW-1:0] P_MAX   = {1'b0, {(PW-1){1'b1}}};
    localparam logic [AW-1:0] ACC_MAX = {{(GW+1){1'b0}}, {(PW-1){1'b1}}};
    localparam logic [AW-1:0] ACC_MIN = {{(GW+1){1'b1}}, {(PW-1){1'b0}}};

    function automatic prod_t frac_mul(input logic [DW-1:0] a, input logic [DW-1:0] b);
        prod_t r;
        logic signed [PW-1:0] ea, eb, raw;
        ea = {{DW{a[DW-1]}}, a};
        eb = {{DW{b[DW-1]}}, b};
        raw = ea * eb;
        if (a == Q_MIN && b == Q_MIN) begin
            r.value = P_MAX;
            r.ovf   = 1'b1;
        end else begin
            r.value = {raw[PW-2:0], 1'b0};
            r.ovf   = 1'b0;
        end
        return r;
    endfunction

    function automatic logic [AW-1:0] sext_prod(input logic [PW-1:0] p);
        return {{GW{p[PW-1]}}, p};
    endfunction

    function automatic limit_t limit_acc(input logic [AW-1:0] a);
        limit_t r;
        logic [GW:0] top;
        top = a[AW-1:PW-1];
        if (top == '0 || top == '1) begin
            r.value   = a;
            r.clamped = 1'b0;
        end else begin
            r.value   = a[AW-1] ? ACC_MIN : ACC_MAX;
            r.clamped = 1'b1;
        end
        return r;
    endfunction

endpackage

// File: rtl/fmac_operands.sv
module fmac_operands
    import fmac_pkg::*;
#(
    parameter int W = DW
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         x_we,
    input  logic [W-1:0] x_in,
    input  logic         y_we,
    input  logic [W-1:0] y_in,
    output logic [W-1:0] x_nxt,
    output logic [W-1:0] y_nxt,
    output logic         mul_go
);
    logic [W-1:0] x_q, y_q;

    always_comb begin
        x_nxt  = x_we ? x_in : x_q;
        y_nxt  = y_we ? y_in : y_q;
        mul_go = x_we | y_we;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            x_q <= '0;
            y_q <= '0;
        end else begin
            x_q <= x_nxt;
            y_q <= y_nxt;
        end
    end
endmodule

// File: rtl/fmac_product.sv
module fmac_product
    import fmac_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          mul_go,
    input  logic [DW-1:0] x_nxt,
    input  logic [DW-1:0] y_nxt,
    output logic [PW-1:0] prod_q,
    output logic          ovf_q
);
    prod_t res;

    always_comb res = frac_mul(x_nxt, y_nxt);

    always_ff @(posedge clk) begin
        if (rst) begin
            prod_q <= '0;
            ovf_q  <= 1'b0;
        end else if (mul_go) begin
            prod_q <= res.value;
            ovf_q  <= res.ovf;
        end
    end

    // Minimum times minimum must saturate and raise the flag.
    assert_sat_R3: assert property (@(posedge clk) disable iff (rst)
        (mul_go && x_nxt == Q_MIN && y_nxt == Q_MIN) |=> (prod_q == P_MAX && ovf_q));

    // No operand write, no change in the product side.
    assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
        !mul_go |=> ($stable(prod_q) && $stable(ovf_q)));
endmodule

// File: rtl/fmac_accum.sv
module fmac_accum
    import fmac_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic [2:0]    op,
    input  logic [PW-1:0] prod,
    output logic [AW-1:0] acc_q,
    output logic          zero_q,
    output logic          neg_q,
    output logic          lim_q
);
    acc_op_e       cmd;
    logic [AW-1:0] acc_d, pext;
    logic          wr, clamp;
    limit_t        lr;

    always_comb begin
        cmd   = acc_op_e'(op);
        pext  = sext_prod(prod);
        lr    = limit_acc(acc_q);
        acc_d = acc_q;
        wr    = 1'b1;
        clamp = 1'b0;
        unique case (cmd)
            OP_LOAD:  acc_d = pext;
            OP_ADD:   acc_d = acc_q + pext;
            OP_SUB:   acc_d = acc_q - pext;
            OP_CLR:   acc_d = '0;
            OP_LIMIT: begin
                acc_d = lr.value;
                clamp = lr.clamped;
            end
            default:  wr = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q  <= '0;
            zero_q <= 1'b1;
            neg_q  <= 1'b0;
            lim_q  <= 1'b0;
        end else begin
            if (wr) begin
                acc_q  <= acc_d;
                zero_q <= (acc_d == '0);
                neg_q  <= acc_d[AW-1];
            end
            if (clamp) lim_q <= 1'b1;
        end
    end

    assert_clear_R7: assert property (@(posedge clk) disable iff (rst)
        (op == 3'd4) |=> (acc_q == '0 && zero_q && !neg_q));

    assert_lim_range_R8: assert property (@(posedge clk) disable iff (rst)
        (op == 3'd5) |=> (acc_q[AW-1:PW-1] == '0 || acc_q[AW-1:PW-1] == '1));

    assert_lim_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        lim_q |=> lim_q);

    assert_flags_R9: assert property (@(posedge clk) disable iff (rst)
        (op >= 3'd1 && op <= 3'd5) |=> (zero_q == (acc_q == '0) && neg_q == acc_q[AW-1]));

    assert_idle_R10: assert property (@(posedge clk) disable iff (rst)
        (op == 3'd0 || op == 3'd6 || op == 3'd7) |=>
            ($stable(acc_q) && $stable(zero_q) && $stable(neg_q)));
endmodule

// File: rtl/fmac_top.sv
module fmac_top
    import fmac_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          x_we,
    input  logic [DW-1:0] x_in,
    input  logic          y_we,
    input  logic [DW-1:0] y_in,
    input  logic [2:0]    acc_op,
    output logic [AW-1:0] acc_out,
    output logic [PW-1:0] prod_out,
    output logic          flag_zero,
    output logic          flag_neg,
    output logic          flag_mulovf,
    output logic          flag_lim
);
    logic [DW-1:0] x_nxt, y_nxt;
    logic          mul_go;

    fmac_operands #(.W(DW)) u_ops (
        .clk(clk), .rst(rst),
        .x_we(x_we), .x_in(x_in), .y_we(y_we), .y_in(y_in),
        .x_nxt(x_nxt), .y_nxt(y_nxt), .mul_go(mul_go)
    );

    fmac_product u_prod (
        .clk(clk), .rst(rst), .mul_go(mul_go),
        .x_nxt(x_nxt), .y_nxt(y_nxt),
        .prod_q(prod_out), .ovf_q(flag_mulovf)
    );

    fmac_accum u_acc (
        .clk(clk), .rst(rst), .op(acc_op), .prod(prod_out),
        .acc_q(acc_out), .zero_q(flag_zero), .neg_q(flag_neg), .lim_q(flag_lim)
    );

    // A product is formed from the value written this cycle, never the stale one.
    assert_fresh_R2: assert property (@(posedge clk) disable iff (rst)
        (x_we && y_we && x_in == 16'h4000 && y_in == 16'h4000) |=> (prod_out == 32'h2000_0000));
endmodule

// File: tb/fmac_top_tb_top.sv
module fmac_top_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        x_we = 1'b0, y_we = 1'b0;
    logic [15:0] x_in = '0, y_in = '0;
    logic [2:0]  acc_op = 3'd0;
    logic [39:0] acc_out;
    logic [31:0] prod_out;
    logic        flag_zero, flag_neg, flag_mulovf, flag_lim;

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    fmac_top dut_i (
        .clk(clk), .rst(rst), .x_we(x_we), .x_in(x_in), .y_we(y_we), .y_in(y_in),
        .acc_op(acc_op), .acc_out(acc_out), .prod_out(prod_out),
        .flag_zero(flag_zero), .flag_neg(flag_neg),
        .flag_mulovf(flag_mulovf), .flag_lim(flag_lim)
    );

    // Behavioural reference model
    longint m_x = 0, m_y = 0, m_p = 0, m_acc = 0;
    bit     m_ovf = 0, m_zero = 1, m_neg = 0, m_lim = 0;
    localparam longint TWO40 = 64'sd1099511627776;
    localparam longint PMAX  = 64'sd2147483647;
    localparam longint PMIN  = -64'sd2147483648;

    function automatic longint wrap40(longint v);
        longint t = v & 64'sh00FF_FFFF_FFFF;
        if (t >= 64'sd549755813888) t = t - TWO40;
        return t;
    endfunction

    always @(posedge clk) begin
        longint old_p, pr;
        bit     wr;
        if (rst) begin
            m_x = 0; m_y = 0; m_p = 0; m_acc = 0;
            m_ovf = 0; m_zero = 1; m_neg = 0; m_lim = 0;
        end else begin
            old_p = m_p;
            if (x_we) m_x = longint'($signed(x_in));
            if (y_we) m_y = longint'($signed(y_in));
            if (x_we || y_we) begin
                pr = m_x * m_y * 2;
                if (pr > PMAX) begin m_p = PMAX; m_ovf = 1; end
                else begin m_p = pr; m_ovf = 0; end
            end
            wr = 1;
            case (acc_op)
                3'd1: m_acc = old_p;
                3'd2: m_acc = wrap40(m_acc + old_p);
                3'd3: m_acc = wrap40(m_acc - old_p);
                3'd4: m_acc = 0;
                3'd5: begin
                    if (m_acc > PMAX) begin m_acc = PMAX; m_lim = 1; end
                    else if (m_acc < PMIN) begin m_acc = PMIN; m_lim = 1; end
                end
                default: wr = 0;
            endcase
            if (wr) begin
                m_zero = (m_acc == 0);
                m_neg  = (m_acc < 0);
            end
        end
    end

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Per-cycle comparison with the model, away from the active edge
    always @(negedge clk) begin
        if (!rst && !done) begin
            chk("R2 product", {32'd0, prod_out}, {32'd0, m_p[31:0]});
            chk("R3 mulovf", {63'd0, flag_mulovf}, {63'd0, m_ovf});
            chk("R6 accumulator", {24'd0, acc_out}, {24'd0, m_acc[39:0]});
            chk("R9 zero", {63'd0, flag_zero}, {63'd0, m_zero});
            chk("R9 neg", {63'd0, flag_neg}, {63'd0, m_neg});
            chk("R8 limflag", {63'd0, flag_lim}, {63'd0, m_lim});
        end
    end

    task automatic step(bit xw, logic [15:0] xv, bit yw, logic [15:0] yv, logic [2:0] op);
        @(negedge clk);
        x_we = xw; x_in = xv; y_we = yw; y_in = yv; acc_op = op;
    endtask

    task automatic idle();
        step(0, 16'h0, 0, 16'h0, 3'd0);
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        #(8 * 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset values
        chk("R1 acc", {24'd0, acc_out}, 64'd0);
        chk("R1 prod", {32'd0, prod_out}, 64'd0);
        chk("R1 flags", {60'd0, flag_zero, flag_neg, flag_mulovf, flag_lim}, 64'h8);

        // R2 both operands in one cycle: 0.5*0.5
        step(1, 16'h4000, 1, 16'h4000, 3'd0); idle();
        chk("R2 half squared", {32'd0, prod_out}, 64'h2000_0000);
        // R2 only Y written, X retained: 0.5 * -1 = -0.5
        step(0, 16'h0, 1, 16'h8000, 3'd0); idle();
        chk("R2 retained x", {32'd0, prod_out}, 64'hC000_0000);
        // R5 load sign-extended product
        step(0, 16'h0, 0, 16'h0, 3'd1); idle();
        chk("R5 load", {24'd0, acc_out}, 64'hFF_C000_0000);
        // R3 saturation
        step(1, 16'h8000, 0, 16'h0, 3'd0); idle();
        chk("R3 sat value", {32'd0, prod_out}, 64'h7FFF_FFFF);
        chk("R3 sat flag", {63'd0, flag_mulovf}, 64'd1);
        // R4 hold with no write, R10 reserved commands
        step(0, 16'h1234, 0, 16'h5678, 3'd6); idle();
        step(0, 16'h0, 0, 16'h0, 3'd7); idle();
        chk("R4 prod hold", {32'd0, prod_out}, 64'h7FFF_FFFF);
        chk("R10 acc hold", {24'd0, acc_out}, 64'hFF_C000_0000);
        // R3 flag clears on next normal multiply
        step(1, 16'h7FFF, 1, 16'h7FFF, 3'd0); idle();
        chk("R3 flag clear", {63'd0, flag_mulovf}, 64'd0);
        // R7 clear
        step(0, 16'h0, 0, 16'h0, 3'd4); idle();
        chk("R7 clear", {24'd0, acc_out}, 64'd0);
        // R6/R8 positive overflow then limit
        repeat (4) step(0, 16'h0, 0, 16'h0, 3'd2);
        idle();
        chk("R6 over 32b", {63'd0, acc_out[39:31] != 9'h0}, 64'd1);
        step(0, 16'h0, 0, 16'h0, 3'd5); idle();
        chk("R8 clamp pos", {24'd0, acc_out}, 64'h00_7FFF_FFFF);
        chk("R8 flag set", {63'd0, flag_lim}, 64'd1);
        // R8 negative clamp
        step(0, 16'h0, 0, 16'h0, 3'd4);
        repeat (4) step(0, 16'h0, 0, 16'h0, 3'd3);
        step(0, 16'h0, 0, 16'h0, 3'd5); idle();
        chk("R8 clamp neg", {24'd0, acc_out}, 64'hFF_8000_0000);
        // R8 in-range limit leaves value alone; R7 keeps sticky flag
        step(0, 16'h0, 0, 16'h0, 3'd4);
        step(0, 16'h0, 0, 16'h0, 3'd1);
        step(0, 16'h0, 0, 16'h0, 3'd5); idle();
        chk("R8 no clamp", {24'd0, acc_out}, 64'h00_7FFE_0002);
        chk("R8 sticky", {63'd0, flag_lim}, 64'd1);
        // R6 40-bit wrap through many adds
        repeat (300) step(0, 16'h0, 0, 16'h0, 3'd2);
        idle();
        // Random phase, all commands
        for (int i = 0; i < 4000; i++) begin
            step(bit'($urandom_range(0, 1)), 16'($urandom),
                 bit'($urandom_range(0, 1)), ($urandom_range(0, 15) == 0) ? 16'h8000 : 16'($urandom),
                 3'($urandom_range(0, 7)));
        end
        idle();
        @(negedge clk);
        finish_run();
    end
endmodule